// File: doc/BRIEF.md
# Dual Window Watchdog Supervisor

This block watches one processor module through two independent window watchdogs. One of them is serviced by the processing section and the other by the communication section. Each section must pulse its own service input inside a time window that is bounded on both sides. A pulse that comes too soon counts as a fault, and so does a pulse that comes too late or never comes. Either fault de-energizes one shared output, and that output is fail-safe. The output is high only while the module is known to be healthy. A low level opens the downstream trip path, so a lock-up, a reset or a loss of power all end in the tripped state.

The shared output is meant to sit in a series chain. The block ANDs its own health with an incoming chain level, which lets several supervisors be cascaded so that any single fault breaks the chain. A sticky two-bit cause field records which section faulted. In the actuation-path build variant, an alarm output follows any recorded fault, so an operator alarm is raised instead of an actuation. All service inputs and outputs are plain control levels; no part of the block streams data, so there is no back-pressure.

Top module: `dual_wwd_supervisor`

## Requirements
- R1: Each section counts clock edges from reset, or from its last valid service pulse. A service pulse is valid when it is sampled high at an edge where that count lies between the section's open limit and its timeout limit minus one, inclusive. Every cycle in which the input is high is a separate pulse.
- R2: A service pulse sampled while the section's count is below its open limit faults that section at the same edge.
- R3: A section that receives no pulse by the edge at which its count equals the timeout limit minus one is faulted at that edge.
- R4: `relay_en` is 1 only while both sections have each given at least one valid pulse since reset and neither section has faulted. After reset it stays 0 until both sections have given a valid pulse.
- R5: A fault in either section drives `relay_en` to 0 right after the same edge that records the fault.
- R6: `cause` bit 0 marks a processing-section fault and bit 1 marks a communication-section fault. Both bits are sticky: only `rst_n` clears them, and later service pulses change neither `cause` nor `relay_en`.
- R7: `chain_out` is 1 exactly when `chain_in` is 1 and `relay_en` is 1.
- R8: With ALARM_MODE=1, `alarm` is 1 exactly when some `cause` bit is set. With ALARM_MODE=0, `alarm` is held at 0.
- R9: While `rst_n` is low, `relay_en`, `chain_out`, `alarm` and both `cause` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset; the only way to clear a fault |
| kick_proc | input | 1 | Service pulse from the processing section |
| kick_comm | input | 1 | Service pulse from the communication section |
| chain_in | input | 1 | Upstream series-chain level (1 = closed) |
| relay_en | output | 1 | Shared fail-safe output, 1 = energized and healthy |
| chain_out | output | 1 | Downstream series-chain level |
| cause | output | 2 | Sticky fault cause: bit 0 processing, bit 1 communication |
| alarm | output | 1 | Operator alarm, used in the actuation-path variant |

## Verification
The bench builds the block with open/timeout limits of 4/10 cycles for the processing section and 6/14 for the communication section, with the alarm variant enabled. Because the windows are short, every early, boundary and late case for both sections, including a timeout in the second window after a valid pulse, completes within about sixteen cycles after reset. Because the two sections use different limits, a single stimulus can fault one section while the other stays healthy, and the cause bits show which one faulted. The alarm follows the cause field throughout.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  // Life cycle of one window supervisor.
  typedef enum logic [1:0] {
    WD_ARMING = 2'd0,  // waiting for the first valid service pulse
    WD_RUN    = 2'd1,  // serviced inside the window at least once
    WD_TRIP   = 2'd2   // fault latched until reset
  } wd_state_e;

  localparam int SEC_PROC = 0;
  localparam int SEC_COMM = 1;
  localparam int N_SEC    = 2;

endpackage

// File: rtl/wwd_window.sv
module wwd_window
  import wwd_pkg::*;
#(
  parameter int OPEN = 4,
  parameter int TMO  = 10,
  localparam int CW  = $clog2(TMO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic ok,
  output logic fault_evt
);

  wd_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          early;
  logic          late;

  // Too soon: a pulse before the window opens.
  // Too late: the last permitted edge passes without a pulse.
  always_comb begin
    early     = kick && (cnt_q < CW'(OPEN));
    late      = !kick && (cnt_q == CW'(TMO - 1));
    fault_evt = (state_q != WD_TRIP) && (early || late);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_ARMING;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        WD_TRIP: begin
          state_q <= WD_TRIP;
          cnt_q   <= cnt_q;
        end
        default: begin
          if (fault_evt) begin
            state_q <= WD_TRIP;
          end else if (kick) begin
            state_q <= WD_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      endcase
    end
  end

  assign ok = (state_q == WD_RUN);

endmodule

// File: rtl/wwd_combine.sv
module wwd_combine #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fault_evt,
  input  logic [N-1:0] ok,
  output logic [N-1:0] cause,
  output logic         relay_en
);

  logic [N-1:0] cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_q | fault_evt;
  end

  assign cause    = cause_q;
  assign relay_en = (&ok) && !(|cause_q);

endmodule

// File: rtl/dual_wwd_supervisor.sv
module dual_wwd_supervisor
  import wwd_pkg::*;
#(
  parameter int PROC_OPEN  = 4,
  parameter int PROC_TMO   = 10,
  parameter int COMM_OPEN  = 6,
  parameter int COMM_TMO   = 14,
  parameter bit ALARM_MODE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick_proc,
  input  logic       kick_comm,
  input  logic       chain_in,
  output logic       relay_en,
  output logic       chain_out,
  output logic [1:0] cause,
  output logic       alarm
);

  logic [N_SEC-1:0] kick_v;
  logic [N_SEC-1:0] ok_v;
  logic [N_SEC-1:0] fault_v;

  assign kick_v[SEC_PROC] = kick_proc;
  assign kick_v[SEC_COMM] = kick_comm;

  for (genvar g = 0; g < N_SEC; g++) begin : g_sec
    localparam int OPEN_G = (g == SEC_PROC) ? PROC_OPEN : COMM_OPEN;
    localparam int TMO_G  = (g == SEC_PROC) ? PROC_TMO  : COMM_TMO;
    wwd_window #(.OPEN(OPEN_G), .TMO(TMO_G)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .kick     (kick_v[g]),
      .ok       (ok_v[g]),
      .fault_evt(fault_v[g])
    );
  end

  wwd_combine #(.N(N_SEC)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_evt(fault_v),
    .ok       (ok_v),
    .cause    (cause),
    .relay_en (relay_en)
  );

  assign chain_out = chain_in && relay_en;

  if (ALARM_MODE) begin : g_alarm
    assign alarm = |cause;
  end else begin : g_noalarm
    assign alarm = 1'b0;
  end

endmodule

// File: rtl/wwd_sva.sv
module wwd_sva #(
  parameter bit ALARM_MODE = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       relay_en,
  input logic       chain_in,
  input logic       chain_out,
  input logic [1:0] cause,
  input logic       alarm
);

  a_r6_proc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cause[0] |=> cause[0]);

  a_r6_comm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cause[1] |=> cause[1]);

  a_r4_relay_clean: assert property (@(posedge clk) disable iff (!rst_n)
    relay_en |-> (cause == 2'b00));

  a_r5_fault_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cause[0]) || $rose(cause[1])) |-> !relay_en);

  a_r7_chain_open: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_in |-> !chain_out);

  if (ALARM_MODE) begin : g_al
    a_r8_alarm_on: assert property (@(posedge clk) disable iff (!rst_n)
      (cause != 2'b00) |-> alarm);
    a_r8_alarm_why: assert property (@(posedge clk) disable iff (!rst_n)
      alarm |-> (cause != 2'b00));
  end else begin : g_noal
    a_r8_alarm_off: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm);
  end

endmodule

bind dual_wwd_supervisor wwd_sva #(.ALARM_MODE(ALARM_MODE)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .relay_en (relay_en),
  .chain_in (chain_in),
  .chain_out(chain_out),
  .cause    (cause),
  .alarm    (alarm)
);

// File: tb/tb_dual_wwd_supervisor.sv
`timescale 1ns/1ps
module tb_dual_wwd_supervisor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kick_p = 1'b0;
  logic       kick_c = 1'b0;
  logic       chain_in = 1'b1;
  logic       relay_en, chain_out, alarm;
  logic [1:0] cause;

  int n_chk = 0;
  int n_bad = 0;
  int cp = 0;
  int cc = 0;

  always #4 clk = ~clk;  // 125 MHz

  dual_wwd_supervisor #(
    .PROC_OPEN(4), .PROC_TMO(10), .COMM_OPEN(6), .COMM_TMO(14), .ALARM_MODE(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .kick_proc(kick_p), .kick_comm(kick_c),
    .chain_in(chain_in), .relay_en(relay_en), .chain_out(chain_out),
    .cause(cause), .alarm(alarm)
  );

  // {proc kick edge, second proc kick edge, comm kick edge, edges run,
  //  expected relay_en, expected cause}; 255 = no pulse.
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {8'd5,   8'd255, 8'd7,   8'd8,  1'b1, 2'd0}, // R1 R4 both in window
    {8'd3,   8'd255, 8'd7,   8'd8,  1'b0, 2'd1}, // R2 proc early
    {8'd5,   8'd255, 8'd5,   8'd8,  1'b0, 2'd2}, // R2 comm early
    {8'd9,   8'd255, 8'd13,  8'd14, 1'b1, 2'd0}, // R1 last legal edge
    {8'd4,   8'd255, 8'd6,   8'd8,  1'b1, 2'd0}, // R1 first legal edge
    {8'd255, 8'd255, 8'd7,   8'd10, 1'b0, 2'd1}, // R3 proc missing
    {8'd5,   8'd255, 8'd255, 8'd14, 1'b0, 2'd2}, // R3 comm missing
    {8'd5,   8'd255, 8'd255, 8'd13, 1'b0, 2'd0}, // R4 comm not yet armed
    {8'd255, 8'd255, 8'd255, 8'd14, 1'b0, 2'd3}, // R3 R5 both missing
    {8'd3,   8'd255, 8'd3,   8'd8,  1'b0, 2'd3}, // R2 both early
    {8'd5,   8'd6,   8'd7,   8'd9,  1'b0, 2'd1}, // R1 R2 pulse held two cycles
    {8'd5,   8'd255, 8'd7,   8'd16, 1'b0, 2'd1}, // R3 late in second window
    {8'd5,   8'd255, 8'd7,   8'd15, 1'b1, 2'd0}  // R3 one edge before timeout
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    kick_p = 1'b0;
    kick_c = 1'b0;
    cp = 0;
    cc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(int kp, int kp2, int kc, int run);
    for (int j = 0; j < run; j++) begin
      kick_p = (j == kp) || (j == kp2);
      kick_c = (j == kc);
      @(posedge clk);
      @(negedge clk);
    end
    kick_p = 1'b0;
    kick_c = 1'b0;
  endtask

  // Periodic servicing: proc every 6 edges, comm every 8 edges.
  task automatic sched(int n, bit en_p, bit en_c);
    for (int i = 0; i < n; i++) begin
      kick_p = en_p && (cp == 5);
      kick_c = en_c && (cc == 7);
      @(posedge clk);
      cp = (cp == 5) ? 0 : cp + 1;
      cc = (cc == 7) ? 0 : cc + 1;
      @(negedge clk);
    end
    kick_p = 1'b0;
    kick_c = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R1..watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R9: reset state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 relay_en", relay_en, 0);
    chk("R9 chain_out", chain_out, 0);
    chk("R9 cause", cause, 0);
    chk("R9 alarm", alarm, 0);

    for (int v = 0; v < NV; v++) begin
      logic [34:0] w;
      w = VEC[v];
      do_reset();
      run_vec(int'(w[34:27]), int'(w[26:19]), int'(w[18:11]), int'(w[10:3]));
      chk($sformatf("R1/R5 relay vec%0d", v), relay_en, int'(w[2]));
      chk($sformatf("R6 cause vec%0d", v), cause, int'(w[1:0]));
      chk($sformatf("R8 alarm vec%0d", v), alarm, int'(w[1:0] != 2'd0));
      chk($sformatf("R7 chain vec%0d", v), chain_out, int'(w[2]));
    end

    // R4: long periodic servicing keeps the output energized
    do_reset();
    sched(60, 1'b1, 1'b1);
    chk("R4 periodic relay", relay_en, 1);
    chain_in = 1'b0;
    #1;
    chk("R7 chain_in low", chain_out, 0);
    chain_in = 1'b1;
    #1;
    chk("R7 chain_in high", chain_out, 1);

    // R3 R5 R8: processing section stops, communication continues
    sched(12, 1'b0, 1'b1);
    chk("R3 proc stop cause", cause, 1);
    chk("R5 proc stop relay", relay_en, 0);
    chk("R8 proc stop alarm", alarm, 1);
    chk("R7 proc stop chain", chain_out, 0);

    // R6: resumed servicing clears nothing
    sched(24, 1'b1, 1'b1);
    chk("R6 sticky cause", cause, 1);
    chk("R6 sticky relay", relay_en, 0);

    // R6 R9: only reset clears the cause
    do_reset();
    chk("R6 reset clears cause", cause, 0);
    chk("R4 power-up relay", relay_en, 0);
    chk("R8 reset clears alarm", alarm, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule